// File: doc/BRIEF.md
# Decimal Matrix Code Write Encoder

This block sits on the write path of a memory that stores each 64-bit word with a decimal matrix code. The data word is viewed as sixteen 4-bit symbols in a logical matrix of two rows and eight columns. The bits are not moved physically. For each column the two symbols are added as unsigned integers, and the carry is kept, which gives a 5-bit horizontal check group. For each bit position the two rows are XORed, which gives a vertical check bit.

The data passes into the codeword unchanged, so the code is systematic. The codeword is packed as {vertical[31:0], horizontal[39:0], data[63:0]}, 136 bits in all.

By default one output register stage follows the combinational encoder. That stage loads only on a valid input. Output valid tracks input valid with the same latency as the codeword.

Top module: `dmc_encoder`

## Requirements
- R1: With the default register stage, out_code[63:0] equals the in_data sampled on the previous rising edge at which in_valid was high.
- R2: For c = 0..7, out_code[64+5c+4 : 64+5c] is the 5-bit unsigned sum of symbol c and symbol c+8, where symbol i is data[4i+3:4i].
- R3: For j = 0..31, out_code[104+j] equals data[j] XOR data[j+32].
- R4: out_valid goes high one clock after in_valid is sampled high, and never earlier.
- R5: While rst_n is low at a rising edge, out_valid and out_code become all zero on that edge.
- R6: A clock edge with in_valid low leaves out_code unchanged and drives out_valid low.
- R7: A group sum that exceeds 15 keeps its carry in the top bit of the group. For example, 15 + 15 gives 5'b11110 and 8 + 8 gives 5'b10000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Data word present this cycle |
| in_data | input | 64 | Data word to encode |
| out_valid | output | 1 | Codeword valid |
| out_code | output | 136 | {vertical, horizontal, data} codeword |

## Verification
The only internal state is the output register, so any fault shows at the ports on the first edge after the offending input.

- A corrupted symbol index or a dropped carry makes one 5-bit group disagree with the arithmetic sum of the two data fields beside it.
- A swapped row pairing breaks the column XOR in that same cycle.
- A load enable that ignores in_valid, or a reset that misses the register, is exposed one cycle later, as a changed codeword or a wrong valid bit.

// File: rtl/dmc_pkg.sv
// Package: shared constants and helpers for the decimal matrix code encoder.
// Assumes a two-row logical matrix; column count and symbol width are parameters of the users.
package dmc_pkg;
    localparam int unsigned DMC_ROWS = 2;

    // Width of one horizontal group: a symbol plus its carry bit.
    function automatic int unsigned grp_width(input int unsigned sym_w);
        return sym_w + 1;
    endfunction
endpackage

// File: rtl/dmc_hsum.sv
// Module: horizontal check generator.
// For each logical column, adds the row-0 symbol and the row-1 symbol as unsigned
// integers and keeps the carry, producing one (SYM_W+1)-bit group per column.
// Assumes row 0 occupies the low half of the word and row 1 the high half.
module dmc_hsum #(
    parameter int unsigned SYM_W  = 4,
    parameter int unsigned N_COLS = 8,
    localparam int unsigned DATA_W = SYM_W * N_COLS * dmc_pkg::DMC_ROWS,
    localparam int unsigned GRP_W  = dmc_pkg::grp_width(SYM_W),
    localparam int unsigned H_W    = GRP_W * N_COLS
) (
    input  logic [DATA_W-1:0] data,
    output logic [H_W-1:0]    hchk
);
    // One adder per column, widened by a zero so the carry survives.
    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        logic [GRP_W-1:0] top_sym;
        logic [GRP_W-1:0] bot_sym;
        assign bot_sym = {1'b0, data[c*SYM_W +: SYM_W]};
        assign top_sym = {1'b0, data[(c+N_COLS)*SYM_W +: SYM_W]};
        assign hchk[c*GRP_W +: GRP_W] = bot_sym + top_sym;
    end
endmodule

// File: rtl/dmc_vpar.sv
// Module: vertical check generator.
// Each check bit is the XOR of the two data bits at the same position in the two rows.
// Assumes a two-row layout with row 1 directly above row 0 in the word.
module dmc_vpar #(
    parameter int unsigned HALF_W = 32,
    localparam int unsigned DATA_W = HALF_W * dmc_pkg::DMC_ROWS
) (
    input  logic [DATA_W-1:0] data,
    output logic [HALF_W-1:0] vchk
);
    // One XOR per column bit position.
    for (genvar j = 0; j < HALF_W; j++) begin : g_bit
        assign vchk[j] = data[j] ^ data[j+HALF_W];
    end
endmodule

// File: rtl/dmc_stage.sv
// Module: optional output stage.
// OUT_REG=1 registers the bus, loading only on valid, with synchronous active-low reset.
// OUT_REG=0 passes the bus and valid straight through.
module dmc_stage #(
    parameter int unsigned W       = 136,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_bus,
    output logic         out_valid,
    output logic [W-1:0] out_bus
);
    if (OUT_REG) begin : g_reg
        // Valid flag register: follows input valid, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) out_valid <= 1'b0;
            else        out_valid <= in_valid;
        end
        // Codeword register: loads on valid, holds otherwise, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)        out_bus <= '0;
            else if (in_valid) out_bus <= in_bus;
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_bus   = in_bus;
    end
endmodule

// File: rtl/dmc_encoder.sv
// Module: decimal matrix code write encoder (top).
// Builds {vertical, horizontal, data} from one data word: horizontal groups are
// unsigned column sums of 4-bit symbols, vertical bits are row-to-row XORs.
// Assumes a two-row logical matrix; data is copied through unchanged (systematic).
module dmc_encoder #(
    parameter int unsigned SYM_W   = 4,
    parameter int unsigned N_COLS  = 8,
    parameter bit          OUT_REG = 1'b1,
    localparam int unsigned DATA_W = SYM_W * N_COLS * dmc_pkg::DMC_ROWS,
    localparam int unsigned HALF_W = DATA_W / dmc_pkg::DMC_ROWS,
    localparam int unsigned H_W    = dmc_pkg::grp_width(SYM_W) * N_COLS,
    localparam int unsigned CW_W   = HALF_W + H_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [CW_W-1:0]   out_code
);
    logic [H_W-1:0]    hchk;
    logic [HALF_W-1:0] vchk;
    logic [CW_W-1:0]   code_nxt;

    dmc_hsum #(.SYM_W(SYM_W), .N_COLS(N_COLS)) i_hsum (
        .data (in_data),
        .hchk (hchk)
    );

    dmc_vpar #(.HALF_W(HALF_W)) i_vpar (
        .data (in_data),
        .vchk (vchk)
    );

    // Codeword packing: vertical on top, horizontal next, data in the low bits.
    assign code_nxt = {vchk, hchk, in_data};

    dmc_stage #(.W(CW_W), .OUT_REG(OUT_REG)) i_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bus    (code_nxt),
        .out_valid (out_valid),
        .out_bus   (out_code)
    );
endmodule

// File: rtl/dmc_encoder_chk.sv
// Module: assertion checker for dmc_encoder, attached by bind.
// Relates the output fields to each other and to the inputs of the prior cycle.
module dmc_encoder_chk #(
    parameter int unsigned SYM_W   = 4,
    parameter int unsigned N_COLS  = 8,
    parameter bit          OUT_REG = 1'b1,
    localparam int unsigned DATA_W = SYM_W * N_COLS * dmc_pkg::DMC_ROWS,
    localparam int unsigned HALF_W = DATA_W / dmc_pkg::DMC_ROWS,
    localparam int unsigned GRP_W  = dmc_pkg::grp_width(SYM_W),
    localparam int unsigned H_W    = GRP_W * N_COLS,
    localparam int unsigned CW_W   = HALF_W + H_W + DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [CW_W-1:0]   out_code
);
    for (genvar c = 0; c < N_COLS; c++) begin : g_grp
        AST_HGROUP_SUM: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_code[DATA_W + c*GRP_W +: GRP_W] ==
                ({1'b0, out_code[c*SYM_W +: SYM_W]} + {1'b0, out_code[(c+N_COLS)*SYM_W +: SYM_W]})); // R2
    end

    AST_VCOL_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_code[DATA_W+H_W +: HALF_W] ==
            (out_code[HALF_W-1:0] ^ out_code[DATA_W-1:HALF_W])); // R3

    if (OUT_REG) begin : g_reg
        AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_code[DATA_W-1:0] == $past(in_data)); // R1
        AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> out_valid == $past(in_valid)); // R4
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_code) && !out_valid); // R6
    end else begin : g_comb
        AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            out_code[DATA_W-1:0] == in_data); // R1
        AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid); // R4
    end
endmodule

bind dmc_encoder dmc_encoder_chk #(
    .SYM_W   (SYM_W),
    .N_COLS  (N_COLS),
    .OUT_REG (OUT_REG)
) i_dmc_encoder_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_code  (out_code)
);

// File: tb/test_dmc_encoder.sv
module test_dmc_encoder;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [63:0]  in_data = '0;
    logic         out_valid;
    logic [135:0] out_code;

    int n_tests = 0;
    int n_fail  = 0;

    dmc_encoder i_dmc_encoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_code(out_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference fields computed arithmetically from the requirements.
    function automatic logic [39:0] ref_h(input logic [63:0] d);
        logic [39:0] h;
        for (int c = 0; c < 8; c++) begin
            int s;
            s = int'(d[4*c +: 4]) + int'(d[4*(c+8) +: 4]);
            h[5*c +: 5] = 5'(s);
        end
        return h;
    endfunction

    function automatic logic [31:0] ref_v(input logic [63:0] d);
        logic [31:0] v;
        for (int j = 0; j < 32; j++) v[j] = d[j] ^ d[j+32];
        return v;
    endfunction

    task automatic check(input string req, input logic [135:0] act, input logic [135:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one valid word at a negedge, check the codeword at the next negedge.
    task automatic apply(input logic [63:0] d);
        in_data  = d;
        in_valid = 1'b1;
        @(negedge clk);
        check("R1", 136'(out_code[63:0]), 136'(d));
        check("R2", 136'(out_code[103:64]), 136'(ref_h(d)));
        check("R3", 136'(out_code[135:104]), 136'(ref_v(d)));
        check("R4", 136'(out_valid), 136'(1));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [135:0] held;
        // R5: reset clears the register even with a valid word present.
        in_valid = 1'b1;
        in_data  = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R5", 136'(out_valid), 136'(0));
        check("R5", out_code, '0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: valid must not rise before the clock edge.
        in_valid = 1'b1;
        in_data  = 64'h0123_4567_89AB_CDEF;
        #1;
        check("R4", 136'(out_valid), 136'(0));
        @(negedge clk);
        check("R4", 136'(out_valid), 136'(1));

        // R2 R7: carry boundaries.
        apply(64'hFFFF_FFFF_FFFF_FFFF);
        check("R7", 136'(out_code[68:64]), 136'(5'b11110));
        apply(64'h8888_8888_8888_8888);
        check("R7", 136'(out_code[68:64]), 136'(5'b10000));
        apply(64'h0000_0000_0000_0000);

        // Near-exhaustive sweep over every symbol pair value, rotated per column.
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                logic [63:0] d;
                for (int c = 0; c < 8; c++) begin
                    d[4*c +: 4]     = 4'(a + c);
                    d[4*(c+8) +: 4] = 4'(b + 3*c);
                end
                apply(d);
            end
        end

        // Single-bit walk for row pairing of vertical bits.
        for (int k = 0; k < 64; k++) apply(64'd1 << k);

        // R6: idle cycles hold the codeword and drop valid.
        apply(64'hDEAD_BEEF_CAFE_F00D);
        held     = out_code;
        in_valid = 1'b0;
        in_data  = 64'h1111_2222_3333_4444;
        @(negedge clk);
        check("R6", out_code, held);
        check("R6", 136'(out_valid), 136'(0));
        in_data = 64'h5555_6666_7777_8888;
        @(negedge clk);
        check("R6", out_code, held);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule